// File: doc/BRIEF.md
# Wake-up pattern filter with masked CRC windows

This block sits on the receive side of an Ethernet MAC and classifies incoming frames for wake-up. It watches the frame byte stream, starting from the first destination-address byte, and runs four independent filters on it. Each filter selects up to 64 bytes from a window that starts a programmable number of bytes into the frame. It hashes the selected bytes with the Ethernet CRC-32 and compares the hash with a programmed signature. Because only a hash is compared, a match is probabilistic rather than exact.

A frame is delivered one byte per cycle with a start strobe on its first byte. A separate end strobe, on a cycle of its own, closes the frame. On that end strobe every filter decides, and the per-filter match flags appear for exactly one cycle. A small join stage folds the four flags into one accept signal. It can OR them, or AND a chosen group and OR in the rest, so one check can span several windows that need not be adjacent. When the system is asleep, a filter that matches also sets its own sticky wake bit.

Top module: `wake_pattern_filter`

## Requirements
- R1: There are four filters. Filter f takes its skip, mask, signature and enable from slice f of each configuration port and matches independently of the other three filters.
- R2: The byte presented with `sof_i` is byte number 0. For filter skip s, frame byte s+b enters the CRC only when bit b of the 64-bit mask is 1; bit b of the mask is `mask_lo` bit b for b<32 and `mask_hi` bit b-32 otherwise. Bytes outside the window and bytes whose mask bit is 0 have no effect on the result.
- R3: The CRC is preset to 0xFFFFFFFF on the start byte, consumes each byte LSB first with reflected polynomial 0xEDB88320, and its complement is compared with the signature. The nine ASCII bytes "123456789" give 0xCBF43926.
- R4: The skip is 11 bits wide, so a window can start at any byte from 0 to 2047.
- R5: The decision is taken on the cycle where `eof_i` is sampled high, whatever was accumulated so far, including from a short frame that ends inside the window. `match_o` is high in the following cycle only, and a byte offered with `byte_vld_i` on the `eof_i` cycle is ignored.
- R6: A filter whose enable bit is 0 never raises its match bit.
- R7: With `join_mode_i`=0, `accept_o` is the OR of the match bits. With `join_mode_i`=1, `accept_o` is (group non-empty AND every filter in `join_grp_i` matched) OR any match outside the group. `accept_o` is valid in the same cycle as `match_o`.
- R8: When `sleep_i` is high on the decision cycle, each matching filter sets its bit of `wake_o`. That bit stays set until reset.
- R9: During and after reset, `match_o`, `accept_o` and `wake_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | A frame byte is present |
| byte_i | input | 8 | Frame byte |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Frame ended; decision cycle, carries no data |
| sleep_i | input | 1 | System is in power-down; wake bits may set |
| cfg_en_i | input | 4 | Per-filter enable |
| cfg_skip_i | input | 44 | Per-filter 11-bit skip, filter f at bits 11f+10..11f |
| cfg_mask_lo_i | input | 128 | Per-filter mask bits 31..0, filter f at 32f+31..32f |
| cfg_mask_hi_i | input | 128 | Per-filter mask bits 63..32, filter f at 32f+31..32f |
| cfg_sig_i | input | 128 | Per-filter expected CRC, filter f at 32f+31..32f |
| join_grp_i | input | 4 | Filters that form the AND group |
| join_mode_i | input | 1 | 0: OR all matches, 1: grouped AND plus OR of the rest |
| match_o | output | 4 | Per-filter match, one-cycle pulse after `eof_i` |
| accept_o | output | 1 | Combined accept, same cycle as `match_o` |
| wake_o | output | 4 | Sticky per-filter wake status |

## Verification
The bench feeds the standard CRC check string and must see 0xCBF43926 match. A design with the wrong preset, bit order or missing final complement would miss it. It changes a byte under a zero mask bit and expects no effect, and it places a window at skip 2047. A wrong mask index or a skip counter that wraps would then hash the wrong bytes. It ends a frame inside its window, and it offers a byte on the end cycle. A design that waits for a full window or that absorbs that byte would report the wrong result. It also drives the join with the group complete, broken and bypassed, and it checks that wake bits set only when asleep and then stay set.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
    localparam int          NUM_FILT   = 4;
    localparam int          SKIP_W     = 11;
    localparam int          WIN_BYTES  = 64;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    // One byte of the reflected Ethernet CRC, LSB of the data first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction
endpackage

// File: rtl/wpf_lane.sv
module wpf_lane
    import wpf_pkg::*;
#(
    parameter int SKIP_W    = wpf_pkg::SKIP_W,
    parameter int WIN_BYTES = wpf_pkg::WIN_BYTES,
    parameter int IDX_W     = SKIP_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_ok_i,
    input  logic                 start_i,
    input  logic [7:0]           byte_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 eof_i,
    input  logic                 en_i,
    input  logic [SKIP_W-1:0]    skip_i,
    input  logic [WIN_BYTES-1:0] mask_i,
    input  logic [31:0]          sig_i,
    output logic                 hit_o
);
    localparam int WB = $clog2(WIN_BYTES);

    typedef struct packed {
        logic [31:0] crc;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [IDX_W-1:0] rel;
    logic             in_win;
    logic             take;
    logic [31:0]      base;

    assign rel    = idx_i - IDX_W'(skip_i);
    assign in_win = (idx_i >= IDX_W'(skip_i)) && (rel < IDX_W'(WIN_BYTES));
    assign take   = byte_ok_i && in_win && mask_i[rel[WB-1:0]];

    always_comb begin
        st_d   = st_q;
        base   = start_i ? CRC_PRESET : st_q.crc;
        st_d.crc = base;
        if (take) begin
            st_d.crc = crc_step(base, byte_i);
        end
        hit_o = eof_i && en_i && ((~st_q.crc) == sig_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{crc: CRC_PRESET};
        end else begin
            st_q <= st_d;
        end
    end

    // A byte outside the mask leaves the running CRC untouched.
    assert_crc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !start_i) |=> $stable(st_q.crc));
endmodule

// File: rtl/wpf_join.sv
module wpf_join #(
    parameter int NUM_FILT = wpf_pkg::NUM_FILT
) (
    input  logic [NUM_FILT-1:0] hit_i,
    input  logic [NUM_FILT-1:0] grp_i,
    input  logic                mode_i,
    output logic                accept_o
);
    logic grp_all;
    logic rest_any;

    always_comb begin
        grp_all  = (|grp_i) && (&(hit_i | ~grp_i));
        rest_any = |(hit_i & ~grp_i);
        accept_o = mode_i ? (grp_all || rest_any) : (|hit_i);
    end
endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
    import wpf_pkg::*;
#(
    parameter int NUM_FILT  = wpf_pkg::NUM_FILT,
    parameter int SKIP_W    = wpf_pkg::SKIP_W,
    parameter int WIN_BYTES = wpf_pkg::WIN_BYTES,
    parameter int HALF_W    = WIN_BYTES / 2,
    parameter int IDX_W     = SKIP_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_vld_i,
    input  logic [7:0]                 byte_i,
    input  logic                       sof_i,
    input  logic                       eof_i,
    input  logic                       sleep_i,
    input  logic [NUM_FILT-1:0]        cfg_en_i,
    input  logic [NUM_FILT*SKIP_W-1:0] cfg_skip_i,
    input  logic [NUM_FILT*HALF_W-1:0] cfg_mask_lo_i,
    input  logic [NUM_FILT*HALF_W-1:0] cfg_mask_hi_i,
    input  logic [NUM_FILT*32-1:0]     cfg_sig_i,
    input  logic [NUM_FILT-1:0]        join_grp_i,
    input  logic                       join_mode_i,
    output logic [NUM_FILT-1:0]        match_o,
    output logic                       accept_o,
    output logic [NUM_FILT-1:0]        wake_o
);
    typedef struct packed {
        logic [IDX_W-1:0]    pos;
        logic [NUM_FILT-1:0] match;
        logic                accept;
        logic [NUM_FILT-1:0] wake;
    } top_st_t;

    top_st_t st_d, st_q;
    logic                byte_ok;
    logic                frame_start;
    logic [IDX_W-1:0]    cur_idx;
    logic [NUM_FILT-1:0] hits;
    logic                join_acc;

    assign byte_ok     = byte_vld_i && !eof_i;
    assign frame_start = byte_ok && sof_i;
    assign cur_idx     = sof_i ? '0 : st_q.pos;

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_lane
        wpf_lane #(
            .SKIP_W   (SKIP_W),
            .WIN_BYTES(WIN_BYTES),
            .IDX_W    (IDX_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .byte_ok_i(byte_ok),
            .start_i  (frame_start),
            .byte_i   (byte_i),
            .idx_i    (cur_idx),
            .eof_i    (eof_i),
            .en_i     (cfg_en_i[f]),
            .skip_i   (cfg_skip_i[f*SKIP_W +: SKIP_W]),
            .mask_i   ({cfg_mask_hi_i[f*HALF_W +: HALF_W], cfg_mask_lo_i[f*HALF_W +: HALF_W]}),
            .sig_i    (cfg_sig_i[f*32 +: 32]),
            .hit_o    (hits[f])
        );
    end

    wpf_join #(.NUM_FILT(NUM_FILT)) join_i (
        .hit_i   (hits),
        .grp_i   (join_grp_i),
        .mode_i  (join_mode_i),
        .accept_o(join_acc)
    );

    always_comb begin
        st_d        = st_q;
        if (byte_ok) begin
            st_d.pos = (cur_idx == '1) ? cur_idx : cur_idx + IDX_W'(1);
        end
        st_d.match  = hits;
        st_d.accept = join_acc;
        st_d.wake   = st_q.wake | (hits & {NUM_FILT{sleep_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o  = st_q.match;
    assign accept_o = st_q.accept;
    assign wake_o   = st_q.wake;

    // Match flags only follow a decision cycle.
    assert_match_after_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.match) |-> $past(eof_i));
    // The byte index never moves backwards inside a frame (saturates past the last window).
    assert_pos_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (st_q.pos >= $past(st_q.pos)));
    // An accept needs at least one filter match.
    assert_accept_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.accept |-> (|st_q.match));

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_chk
        assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.match[f] |-> $past(cfg_en_i[f]));
        assert_wake_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.wake[f] |=> st_q.wake[f]);
        assert_wake_needs_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.wake[f]) |-> $past(sleep_i));
    end
endmodule

// File: tb/wake_pattern_filter_tb_top.sv
module wake_pattern_filter_tb_top;
    localparam int NF = 4;

    typedef struct packed {
        logic [10:0] skip;
        logic [63:0] mask;
        logic [11:0] len;
        logic        good;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{skip: 11'd0,   mask: 64'hFFFF_FFFF_FFFF_FFFF, len: 12'd64,  good: 1'b1},
        '{skip: 11'd5,   mask: 64'h0000_0000_0000_F0F0, len: 12'd40,  good: 1'b1},
        '{skip: 11'd14,  mask: 64'h8000_0000_0000_0001, len: 12'd100, good: 1'b1},
        '{skip: 11'd20,  mask: 64'hFFFF_FFFF_FFFF_FFFF, len: 12'd50,  good: 1'b1},
        '{skip: 11'd3,   mask: 64'hFFFF_0000_FFFF_0000, len: 12'd80,  good: 1'b0},
        '{skip: 11'd100, mask: 64'h0000_FFFF_0000_0000, len: 12'd200, good: 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           byte_vld = 1'b0;
    logic [7:0]     byte_d = 8'h0;
    logic           sof = 1'b0;
    logic           eof = 1'b0;
    logic           sleep = 1'b0;
    logic [NF-1:0]  cfg_en = '0;
    logic [NF*11-1:0] cfg_skip = '0;
    logic [NF*32-1:0] cfg_mlo = '0;
    logic [NF*32-1:0] cfg_mhi = '0;
    logic [NF*32-1:0] cfg_sig = '0;
    logic [NF-1:0]  grp = '0;
    logic           mode = 1'b0;
    logic [NF-1:0]  match;
    logic           accept;
    logic [NF-1:0]  wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] fr [0:2199];

    always #4 clk = ~clk;

    wake_pattern_filter dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_d),
        .sof_i(sof), .eof_i(eof), .sleep_i(sleep), .cfg_en_i(cfg_en),
        .cfg_skip_i(cfg_skip), .cfg_mask_lo_i(cfg_mlo), .cfg_mask_hi_i(cfg_mhi),
        .cfg_sig_i(cfg_sig), .join_grp_i(grp), .join_mode_i(mode),
        .match_o(match), .accept_o(accept), .wake_o(wake)
    );

    function automatic logic [31:0] model_crc(int skip, logic [63:0] mask, int len);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < len; k++) begin
            int b;
            b = k - skip;
            if (b >= 0 && b < 64 && mask[b]) begin
                for (int i = 0; i < 8; i++) begin
                    logic fb;
                    fb = c[0] ^ fr[k][i];
                    c = c >> 1;
                    if (fb) c = c ^ 32'hEDB8_8320;
                end
            end
        end
        return ~c;
    endfunction

    task automatic fill(int seed);
        for (int k = 0; k < 2200; k++) fr[k] = 8'(k * 37 + seed * 11 + 5);
    endtask

    task automatic prog(int f, int skip, logic [63:0] mask, logic [31:0] sig, logic en);
        cfg_skip[f*11 +: 11] = 11'(skip);
        cfg_mlo[f*32 +: 32]  = mask[31:0];
        cfg_mhi[f*32 +: 32]  = mask[63:32];
        cfg_sig[f*32 +: 32]  = sig;
        cfg_en[f]            = en;
    endtask

    task automatic run_frame(int len, bit vld_on_eof);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            byte_vld = 1'b1; sof = (k == 0); byte_d = fr[k];
        end
        @(negedge clk);
        byte_vld = vld_on_eof; sof = 1'b0; byte_d = fr[len]; eof = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; eof = 1'b0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] s0, s1, s2;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 match", 32'(match), 0);
        check("R9 accept", 32'(accept), 0);
        check("R9 wake", 32'(wake), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", 32'({match, accept, wake}), 0);

        // R1/R2/R5 vector table: vector i programs filter i%4 only
        for (int i = 0; i < 6; i++) begin
            int f;
            logic [31:0] m;
            f = i % NF;
            fill(i);
            m = model_crc(int'(VEC[i].skip), VEC[i].mask, int'(VEC[i].len));
            cfg_en = '0; mode = 1'b0; grp = '0;
            prog(f, int'(VEC[i].skip), VEC[i].mask, VEC[i].good ? m : m ^ 32'h1, 1'b1);
            run_frame(int'(VEC[i].len), 1'b0);
            check("R1 R2 vector match", 32'(match), 32'(VEC[i].good) << f);
            check("R7 vector accept or-mode", 32'(accept), 32'(VEC[i].good));
        end

        // R3: standard check string
        for (int k = 0; k < 9; k++) fr[k] = 8'h31 + 8'(k);
        cfg_en = '0;
        prog(0, 0, 64'h1FF, 32'hCBF4_3926, 1'b1);
        run_frame(9, 1'b0);
        check("R3 check string", 32'(match), 32'h1);
        // R5: pulse lasts one cycle
        @(negedge clk);
        check("R5 one-cycle pulse", 32'(match), 0);

        // R2: a change under a zero mask bit has no effect; under a one bit it breaks the match
        fill(7);
        s0 = model_crc(5, 64'h0000_0000_0000_F0F0, 40);
        prog(0, 5, 64'h0000_0000_0000_F0F0, s0, 1'b1);
        fr[5 + 2] = fr[5 + 2] ^ 8'h5A;
        run_frame(40, 1'b0);
        check("R2 masked-out byte ignored", 32'(match), 32'h1);
        fr[5 + 4] = fr[5 + 4] ^ 8'h01;
        run_frame(40, 1'b0);
        check("R2 masked-in byte counts", 32'(match), 0);

        // R6: disabled filter with correct signature stays silent
        fill(7);
        prog(0, 5, 64'h0000_0000_0000_F0F0, s0, 1'b0);
        run_frame(40, 1'b0);
        check("R6 disabled match", 32'(match), 0);
        check("R6 disabled accept", 32'(accept), 0);

        // R4: window at skip 2047
        fill(9);
        s0 = model_crc(2047, 64'h3, 2050);
        prog(0, 2047, 64'h3, s0, 1'b1);
        run_frame(2050, 1'b0);
        check("R4 skip 2047", 32'(match), 32'h1);
        fr[2046] = fr[2046] ^ 8'hFF;
        run_frame(2050, 1'b0);
        check("R4 byte 2046 outside", 32'(match), 32'h1);

        // R5: short frame inside the window, and a byte on the eof cycle ignored
        fill(11);
        s0 = model_crc(10, 64'hFFFF_FFFF_FFFF_FFFF, 30);
        prog(0, 10, 64'hFFFF_FFFF_FFFF_FFFF, s0, 1'b1);
        run_frame(30, 1'b1);
        check("R5 truncated window + eof byte", 32'(match), 32'h1);

        // R7: join stage, three windows of one frame
        fill(13);
        cfg_en = '0;
        s0 = model_crc(0, 64'hFF, 120);
        s1 = model_crc(40, 64'hFFFF, 120);
        s2 = model_crc(90, 64'h0F0F, 120);
        grp = 4'b0011; mode = 1'b1;
        prog(0, 0, 64'hFF, s0, 1'b1);
        prog(1, 40, 64'hFFFF, s1, 1'b1);
        prog(2, 90, 64'h0F0F, s2 ^ 32'h1, 1'b1);
        run_frame(120, 1'b0);
        check("R7 group complete match", 32'(match), 32'h3);
        check("R7 group complete accept", 32'(accept), 1);
        prog(1, 40, 64'hFFFF, s1 ^ 32'h1, 1'b1);
        run_frame(120, 1'b0);
        check("R7 group broken accept", 32'(accept), 0);
        mode = 1'b0;
        run_frame(120, 1'b0);
        check("R7 or-mode accept", 32'(accept), 1);
        mode = 1'b1;
        prog(0, 0, 64'hFF, s0 ^ 32'h1, 1'b1);
        prog(2, 90, 64'h0F0F, s2, 1'b1);
        run_frame(120, 1'b0);
        check("R7 outside-group accept", 32'(accept), 1);
        check("R7 outside-group match", 32'(match), 32'h4);

        // R8: sticky wake status
        prog(0, 0, 64'hFF, s0, 1'b1);
        prog(1, 40, 64'hFFFF, s1, 1'b1);
        prog(2, 90, 64'h0F0F, s2 ^ 32'h1, 1'b1);
        sleep = 1'b0;
        run_frame(120, 1'b0);
        check("R8 awake no wake", 32'(wake), 0);
        prog(0, 0, 64'hFF, s0 ^ 32'h1, 1'b1);
        sleep = 1'b1;
        run_frame(120, 1'b0);
        check("R8 wake set", 32'(wake), 32'h2);
        prog(1, 40, 64'hFFFF, s1 ^ 32'h1, 1'b1);
        run_frame(120, 1'b0);
        check("R8 wake sticky", 32'(wake), 32'h2);
        prog(0, 0, 64'hFF, s0, 1'b1);
        run_frame(120, 1'b0);
        check("R8 wake accumulates", 32'(wake), 32'h3);
        sleep = 1'b0;

        finish_run();
    end
endmodule